// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block produces the four primary-side switch commands of a phase-shifted full bridge. A leading leg (outputs A and B) changes state only on a one-cycle period pulse from the oscillator. A lagging leg (outputs C and D) changes state once per half period, on a trip from the phase comparator or, if it comes first, on a trip from the cycle-by-cycle current limiter. The two power-transfer diagonals are A with D and B with C. The time between a leading-leg transition and the next lagging-leg transition therefore sets the effective duty. It can range from zero overlap up to nearly a full half period.

Each leg has its own dead-time stage. When a leg changes state, the outgoing output drops at once and the incoming output rises a programmable number of clock cycles later. A count of zero gives a direct complementary swap. A lockout input clears the sequence and holds every output low. Once lockout is released, nothing is driven until the next period pulse. That pulse restarts the bridge on the A/D diagonal.

The comparators, the error amplifier and the drivers are outside the block. Their decisions arrive as synchronous single-bit inputs.

Top module: `psfb_gate_seq`

## Requirements
- R1: During reset and after it, all four outputs are low, and they stay low until lockout is low and a period pulse has been seen.
- R2: While lockout_i is high, all four outputs are low in that same cycle. The sequence state is cleared, and period pulses have no effect.
- R3: The first period pulse sampled at edge E after lockout is released starts the bridge. The outputs stay low after edge E+1. D is high after edge E+1+dt_cd_i and A is high after edge E+1+dt_ab_i.
- R4: Each later period pulse sampled at edge E swaps the A/B leg. The output that was on goes low after edge E+1, and the other goes high after edge E+1+dt_ab_i.
- R5: A phase trip sampled at edge T swaps the C/D leg. The output that was on goes low after edge T+1, and the other goes high after edge T+1+dt_cd_i.
- R6: A current-limit trip swaps the C/D leg with the same timing as a phase trip.
- R7: At most one C/D swap occurs per half period. A trip after the first one is ignored until the next period pulse, and so is a trip sampled in the same cycle as a period pulse.
- R8: A dead count of zero swaps the leg directly: the outgoing output falls and the incoming output rises after the same edge E+1.
- R9: The two outputs of a leg are never high together.
- R10: After lockout is released, the restart again brings up A and D first, and no output pulses before that period pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 1 | One-cycle period pulse from the oscillator |
| phase_trip_i | input | 1 | Phase comparator trip |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit trip |
| lockout_i | input | 1 | High forces all outputs low and clears the sequence |
| dt_ab_i | input | DT_W | Dead time of the A/B leg, in clock cycles |
| dt_cd_i | input | DT_W | Dead time of the C/D leg, in clock cycles |
| gate_a_o | output | 1 | Leading leg, high side |
| gate_b_o | output | 1 | Leading leg, low side |
| gate_c_o | output | 1 | Lagging leg, high side |
| gate_d_o | output | 1 | Lagging leg, low side |

## Verification
A pulse or trip sampled at edge N passes through two registers: the leg-select register and the dead-time stage. The outgoing output therefore falls after edge N+1, and the incoming output rises after edge N+1+dead count. Lockout is the one exception: it masks the outputs combinationally within the same cycle. For each stimulus, the driver records the edge number at which it was sampled and queues the expected output word for the exact later edge numbers. The monitor compares that word at the falling clock edge of that cycle. Ignored trips are checked by confirming that the lagging leg holds its level over a window longer than its dead count.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_AB = 0;
  localparam int unsigned LEG_CD = 1;
endpackage

// File: rtl/psfb_phase_ctrl.sv
module psfb_phase_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lockout_i,
  input  logic res_i,
  input  logic trip_i,
  output logic run_o,
  output logic ab_sel_o,
  output logic cd_sel_o
);
  logic run_q, ab_sel_q, cd_sel_q, cd_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      ab_sel_q  <= 1'b0;
      cd_sel_q  <= 1'b0;
      cd_done_q <= 1'b0;
    end else if (lockout_i) begin
      run_q     <= 1'b0;
      ab_sel_q  <= 1'b0;
      cd_sel_q  <= 1'b0;
      cd_done_q <= 1'b0;
    end else if (res_i) begin
      cd_done_q <= 1'b0;
      if (!run_q) begin
        // restart on the A/D diagonal
        run_q    <= 1'b1;
        ab_sel_q <= 1'b1;
        cd_sel_q <= 1'b1;
      end else begin
        ab_sel_q <= ~ab_sel_q;
      end
    end else if (run_q && trip_i && !cd_done_q) begin
      cd_sel_q  <= ~cd_sel_q;
      cd_done_q <= 1'b1;
    end
  end

  assign run_o    = run_q;
  assign ab_sel_o = ab_sel_q;
  assign cd_sel_o = cd_sel_q;

  p_one_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cd_done_q && !res_i && !lockout_i |=> $stable(cd_sel_q));
  p_res_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && res_i && !lockout_i |=> ab_sel_q != $past(ab_sel_q));
  p_start_diag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ab_sel_q && cd_sel_q);
  p_lock_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> !run_q);
endmodule

// File: rtl/psfb_leg_deadtime.sv
module psfb_leg_deadtime
  import psfb_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sel_i,
  input  logic [DT_W-1:0] dt_i,
  output leg_pair_t       pair_o
);
  localparam logic [DT_W-1:0] CNT_ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic [DT_W-1:0] cnt_q;
  logic sel_q, act_q, hi_q, lo_q;
  logic change;

  assign change = !act_q || (sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      act_q <= 1'b0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      act_q <= 1'b0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (change) begin
      act_q <= 1'b1;
      sel_q <= sel_i;
      if (dt_i == '0) begin
        hi_q  <= sel_i;
        lo_q  <= ~sel_i;
        cnt_q <= '0;
      end else begin
        hi_q  <= 1'b0;
        lo_q  <= 1'b0;
        cnt_q <= dt_i;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        hi_q <= sel_q;
        lo_q <= ~sel_q;
      end
    end
  end

  assign pair_o.hi = hi_q;
  assign pair_o.lo = lo_q;

  p_pair_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));
  p_off_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hi_q && !lo_q);
endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_i,
  input  logic            phase_trip_i,
  input  logic            ilim_trip_i,
  input  logic            lockout_i,
  input  logic [DT_W-1:0] dt_ab_i,
  input  logic [DT_W-1:0] dt_cd_i,
  output logic            gate_a_o,
  output logic            gate_b_o,
  output logic            gate_c_o,
  output logic            gate_d_o
);
  logic run, ab_sel, cd_sel, leg_en;
  logic [NUM_LEGS-1:0] leg_sel;
  logic [NUM_LEGS-1:0][DT_W-1:0] leg_dt;
  leg_pair_t [NUM_LEGS-1:0] leg_out;

  psfb_phase_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lockout_i (lockout_i),
    .res_i     (res_i),
    .trip_i    (phase_trip_i | ilim_trip_i),
    .run_o     (run),
    .ab_sel_o  (ab_sel),
    .cd_sel_o  (cd_sel)
  );

  assign leg_en          = run & ~lockout_i;
  assign leg_sel[LEG_AB] = ab_sel;
  assign leg_sel[LEG_CD] = ~cd_sel; // cd_sel high selects D (low side)
  assign leg_dt[LEG_AB]  = dt_ab_i;
  assign leg_dt[LEG_CD]  = dt_cd_i;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg_deadtime #(.DT_W(DT_W)) u_dt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (leg_en),
      .sel_i  (leg_sel[g]),
      .dt_i   (leg_dt[g]),
      .pair_o (leg_out[g])
    );
  end

  assign gate_a_o = leg_out[LEG_AB].hi & ~lockout_i;
  assign gate_b_o = leg_out[LEG_AB].lo & ~lockout_i;
  assign gate_c_o = leg_out[LEG_CD].hi & ~lockout_i;
  assign gate_d_o = leg_out[LEG_CD].lo & ~lockout_i;

  p_lock_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lockout_i) |-> !leg_out[LEG_AB].hi && !leg_out[LEG_AB].lo
                       && !leg_out[LEG_CD].hi && !leg_out[LEG_CD].lo);
endmodule

// File: tb/sim_psfb_gate_seq.sv
module sim_psfb_gate_seq;
  localparam int DT_W = 8;

  typedef struct {
    int       cyc;
    logic [3:0] val;
    string    tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res = 1'b0, ptrip = 1'b0, itrip = 1'b0, lock = 1'b1;
  logic [DT_W-1:0] dt_ab = 8'd3, dt_cd = 8'd2;
  logic ga, gb, gc, gd;
  logic [3:0] outs;
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign outs = {ga, gb, gc, gd};

  psfb_gate_seq #(.DT_W(DT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .phase_trip_i(ptrip),
    .ilim_trip_i(itrip), .lockout_i(lock), .dt_ab_i(dt_ab), .dt_cd_i(dt_cd),
    .gate_a_o(ga), .gate_b_o(gb), .gate_c_o(gc), .gate_d_o(gd)
  );

  task automatic expect_at(input int c, input logic [3:0] v, input string tag);
    exp_t e;
    int i;
    e.cyc = c; e.val = v; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].cyc <= c) i++;
    q.insert(i, e);
  endtask

  task automatic chk_now(input logic [3:0] v, input string tag);
    n_cmp++;
    if (outs !== v) begin
      n_bad++;
      $display("FAIL %s: outs(abcd)=%b expected %b at cyc %0d", tag, outs, v, cyc);
    end
  endtask

  // kind: 0 res, 1 phase trip, 2 current-limit trip, 3 res with phase trip
  task automatic pulse(input int kind, output int e);
    @(negedge clk);
    res   = (kind == 0 || kind == 3);
    ptrip = (kind == 1 || kind == 3);
    itrip = (kind == 2);
    e = cyc + 1;
    @(negedge clk);
    res = 0; ptrip = 0; itrip = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (e.cyc != cyc || outs !== e.val) begin
        n_bad++;
        $display("FAIL %s: outs(abcd)=%b expected %b at cyc %0d (due %0d)",
                 e.tag, outs, e.val, cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e, t;
    idle(3);
    chk_now(4'b0000, "R1 in reset");
    rst_n = 1;
    idle(2);
    chk_now(4'b0000, "R1 after reset");

    // period pulse under lockout: no effect
    pulse(0, e);
    expect_at(e + 1, 4'b0000, "R2 lockout ignores res");
    expect_at(e + 5, 4'b0000, "R2 lockout ignores res");
    idle(7);

    lock = 0;
    expect_at(cyc + 4, 4'b0000, "R1 idle before first res");
    idle(6);

    // start
    pulse(0, e);
    expect_at(e + 1, 4'b0000, "R3 start dead");
    expect_at(e + 3, 4'b0001, "R3 D on");
    expect_at(e + 4, 4'b1001, "R3 A on");
    idle(6);

    // phase trip swaps C/D
    pulse(1, t);
    expect_at(t + 1, 4'b1000, "R5 D off");
    expect_at(t + 3, 4'b1010, "R5 C on");
    idle(4);
    // second trip in same half period ignored
    pulse(1, t);
    expect_at(t + 1, 4'b1010, "R7 second trip");
    expect_at(t + 4, 4'b1010, "R7 second trip");
    idle(6);

    // period pulse swaps A/B
    pulse(0, e);
    expect_at(e + 1, 4'b0010, "R4 A off");
    expect_at(e + 3, 4'b0010, "R4 dead window");
    expect_at(e + 4, 4'b0110, "R4 B on");
    idle(6);

    // current-limit trip
    pulse(2, t);
    expect_at(t + 1, 4'b0100, "R6 C off");
    expect_at(t + 3, 4'b0101, "R6 D on");
    idle(4);
    pulse(2, t);
    expect_at(t + 4, 4'b0101, "R7 second limit trip");
    idle(6);

    // trip coinciding with period pulse ignored for C/D
    pulse(3, e);
    expect_at(e + 1, 4'b0001, "R4 B off");
    expect_at(e + 4, 4'b1001, "R7 coincident trip");
    idle(6);
    pulse(1, t);
    expect_at(t + 1, 4'b1000, "R5 trip after coincident");
    expect_at(t + 3, 4'b1010, "R5 trip after coincident");
    idle(6);

    // zero dead counts
    dt_ab = 0;
    pulse(0, e);
    expect_at(e + 1, 4'b0110, "R8 direct A/B swap");
    idle(4);
    dt_cd = 0;
    pulse(1, t);
    expect_at(t + 1, 4'b0101, "R8 direct C/D swap");
    idle(4);

    // lockout mid-run
    @(negedge clk);
    lock = 1;
    #1 chk_now(4'b0000, "R2 immediate low");
    idle(3);
    chk_now(4'b0000, "R2 held low");
    pulse(0, e);
    expect_at(e + 2, 4'b0000, "R2 res under lockout");
    idle(5);

    // release and restart
    dt_ab = 3; dt_cd = 2;
    lock = 0;
    expect_at(cyc + 5, 4'b0000, "R10 quiet after release");
    idle(7);
    pulse(0, e);
    expect_at(e + 1, 4'b0000, "R10 restart dead");
    expect_at(e + 3, 4'b0001, "R10 restart D");
    expect_at(e + 4, 4'b1001, "R10 restart A");
    idle(10);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL queue: %0d pending, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule